// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the column addresses of every data beat of a DRAM burst. A request is a one-cycle start pulse carrying a starting column, a two-bit length code and an ordering bit. From the next clock onward the block gives one column address per cycle. Each address comes with a valid flag, and the final beat also raises a last flag.

Only the low column bits inside the aligned burst block change. The bits above that field are copied from the start column. In wrapping-increment order the low field counts up modulo the burst length. In interleaved order the low field is the start value XOR the beat index. A new start pulse always takes over at once: it cuts short a running burst, and when it arrives with the last beat it follows on with no idle cycle. An illegal length code yields no beats and raises an error flag for one cycle.

Top module: `burst_col_seq`

## Requirements
- R1: Length code 1 yields 2 beats, 2 yields 4 beats and 3 yields 8 beats. `beat_vld_o` is high for exactly that many consecutive cycles, starting in the cycle after the start pulse, when no further start arrives.
- R2: The first beat's column equals the start column presented with the start pulse.
- R3: With `ilv_i` = 0, the low log2(N) bits of beat k equal (start low bits + k) mod N, where N is the burst length.
- R4: With `ilv_i` = 1, the low log2(N) bits of beat k equal (start low bits) XOR k.
- R5: Every column bit above the low log2(N) bits equals the start column for the whole burst.
- R6: `beat_last_o` is high on the final beat of a burst only, and never without `beat_vld_o`.
- R7: A start with length code 0 produces no beats, ends any burst in progress, and raises `bad_len_o` for exactly the one cycle after the start.
- R8: A start during a running burst abandons it; the next cycle carries beat 0 of the new burst.
- R9: A start in the same cycle as the last beat is followed directly by beat 0 of the new burst, with no idle cycle.
- R10: After synchronous reset, `beat_vld_o`, `beat_last_o` and `bad_len_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle burst request |
| col_i | input | COL_W | Starting column of the burst |
| blen_i | input | 2 | Length code: 1=2, 2=4, 3=8 beats, 0 illegal |
| ilv_i | input | 1 | Ordering: 0 wrapping increment, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | Current beat is valid |
| beat_last_o | output | 1 | Current beat is the last of its burst |
| bad_len_o | output | 1 | Previous cycle's start had an illegal length code |

## Verification
The assertions assume that `col_i`, `blen_i` and `ilv_i` are meaningful only while `start_i` is high. They also assume the column is at least four bits wide, so that a field above the widest burst block exists. The stimulus changes the request inputs only on the falling clock edge and lowers `start_i` after one cycle. It covers every legal code in both orderings, with start columns at the edges of their blocks. It also truncates bursts with legal and illegal codes, and chains a new burst onto a last beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BL_CODE_W = 2;
  localparam int BEAT_W    = 3;

  typedef logic [BL_CODE_W-1:0] bl_code_t;
  typedef logic [BEAT_W-1:0]    beat_idx_t;

  typedef enum logic [BL_CODE_W-1:0] {
    BL_BAD = 2'd0,
    BL_2   = 2'd1,
    BL_4   = 2'd2,
    BL_8   = 2'd3
  } bl_sel_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_seq_pkg::*;
(
  input  bl_code_t  code,
  output beat_idx_t mask,
  output logic      legal
);
  always_comb begin
    mask  = '0;
    legal = 1'b1;
    case (bl_sel_e'(code))
      BL_2:    mask = 3'b001;
      BL_4:    mask = 3'b011;
      BL_8:    mask = 3'b111;
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  beat_idx_t        idx,
  input  beat_idx_t        mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  beat_idx_t low_start;
  beat_idx_t off;

  assign low_start = base[BEAT_W-1:0];
  assign off = ilv ? (low_start ^ idx) : (low_start + idx);
  assign col = {base[COL_W-1:BEAT_W], (low_start & ~mask) | (off & mask)};
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             beat_last_o,
  output logic             bad_len_o
);
  beat_idx_t        mask_d;
  logic             legal_d;
  logic [COL_W-1:0] next_col;

  logic [COL_W-1:0] base_q;
  beat_idx_t        mask_q;
  beat_idx_t        idx_q;
  logic             ilv_q;
  logic [COL_W-1:0] col_q;
  logic             vld_q;
  logic             last_q;
  logic             bad_q;

  burst_len_decode u_dec (
    .code  (blen_i),
    .mask  (mask_d),
    .legal (legal_d)
  );

  burst_addr_calc #(.COL_W(COL_W)) u_calc (
    .base (base_q),
    .idx  (idx_q),
    .mask (mask_q),
    .ilv  (ilv_q),
    .col  (next_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '0;
      idx_q  <= '0;
      ilv_q  <= 1'b0;
      col_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      bad_q <= start_i & ~legal_d;
      if (start_i) begin
        last_q <= 1'b0;
        if (legal_d) begin
          base_q <= col_i;
          mask_q <= mask_d;
          ilv_q  <= ilv_i;
          idx_q  <= 3'd1;
          col_q  <= col_i;
          vld_q  <= 1'b1;
        end else begin
          vld_q <= 1'b0;
        end
      end else if (vld_q && !last_q) begin
        col_q  <= next_col;
        last_q <= (idx_q == mask_q);
        idx_q  <= idx_q + 3'd1;
      end else begin
        vld_q  <= 1'b0;
        last_q <= 1'b0;
      end
    end
  end

  assign col_o       = col_q;
  assign beat_vld_o  = vld_q;
  assign beat_last_o = last_q;
  assign bad_len_o   = bad_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic [1:0]       blen_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_vld_o,
  input logic             beat_last_o,
  input logic             bad_len_o
);
  assert_first_col_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && blen_i != 2'd0) |=> (beat_vld_o && !beat_last_o && col_o == $past(col_i)));

  assert_upper_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !beat_last_o && !start_i) |=>
      (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

  assert_last_needs_vld_R6: assert property (@(posedge clk) disable iff (rst)
    beat_last_o |-> beat_vld_o);

  assert_bad_no_beat_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && blen_i == 2'd0) |=> (bad_len_o && !beat_vld_o));

  assert_bad_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !bad_len_o);

  assert_no_gap_R1: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !beat_last_o && !start_i) |=> beat_vld_o);

  assert_no_spont_R1: assert property (@(posedge clk) disable iff (rst)
    ((!beat_vld_o || beat_last_o) && !start_i) |=> !beat_vld_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .col_i       (col_i),
  .blen_i      (blen_i),
  .col_o       (col_o),
  .beat_vld_o  (beat_vld_o),
  .beat_last_o (beat_last_o),
  .bad_len_o   (bad_len_o)
);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
  localparam int COL_W = 8;
  localparam int NVEC  = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [1:0]       blen_i = '0;
  logic             ilv_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             beat_vld_o, beat_last_o, bad_len_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .col_i(col_i), .blen_i(blen_i),
    .ilv_i(ilv_i), .col_o(col_o), .beat_vld_o(beat_vld_o),
    .beat_last_o(beat_last_o), .bad_len_o(bad_len_o)
  );

  // {blen[1:0], ilv, col[7:0], expected beats (beat k at bits 8k+7:8k)}
  localparam logic [74:0] VEC [NVEC] = '{
    {2'd3, 1'b0, 8'h12, 64'h11101716_15141312},
    {2'd2, 1'b1, 8'h21, 64'h00000000_22232021},
    {2'd3, 1'b1, 8'h35, 64'h32333031_36373435},
    {2'd1, 1'b0, 8'h47, 64'h00000000_00004647},
    {2'd2, 1'b0, 8'hFE, 64'h00000000_FDFCFFFE},
    {2'd3, 1'b1, 8'hA0, 64'hA7A6A5A4_A3A2A1A0},
    {2'd1, 1'b1, 8'h0A, 64'h00000000_00000B0A}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic beat(input string tag, input logic [7:0] c, input logic last);
    check({tag, " vld"}, 32'(beat_vld_o), 32'd1);
    check({tag, " col"}, 32'(col_o), 32'(c));
    check({tag, " last"}, 32'(beat_last_o), 32'(last));
  endtask

  task automatic req(input logic [1:0] bl, input logic il, input logic [7:0] c);
    start_i = 1'b1; blen_i = bl; ilv_i = il; col_i = c;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 vld", 32'(beat_vld_o), 32'd0);
    check("R10 last", 32'(beat_last_o), 32'd0);
    check("R10 bad", 32'(bad_len_o), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // Table: R1 length, R2 first column, R3/R4 order, R5 upper bits, R6 last
    for (int v = 0; v < NVEC; v++) begin
      automatic logic [1:0]  bl = VEC[v][74:73];
      automatic int          nb = 1 << bl;
      req(bl, VEC[v][72], VEC[v][71:64]);
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < nb; k++) begin
        beat(VEC[v][72] ? "R4 R5 R6" : "R3 R5 R6", VEC[v][8*k +: 8], k == nb - 1);
        if (k == 0) check("R2 first", 32'(col_o), 32'(VEC[v][71:64]));
        @(negedge clk);
      end
      check("R1 end of burst", 32'(beat_vld_o), 32'd0);
    end

    // R7: illegal code from idle
    req(2'd0, 1'b0, 8'h33);
    @(negedge clk);
    start_i = 1'b0;
    check("R7 bad", 32'(bad_len_o), 32'd1);
    check("R7 no beat", 32'(beat_vld_o), 32'd0);
    @(negedge clk);
    check("R7 bad drops", 32'(bad_len_o), 32'd0);
    check("R7 still idle", 32'(beat_vld_o), 32'd0);

    // R7: illegal code aborts a running burst
    req(2'd3, 1'b0, 8'h40);
    @(negedge clk);
    start_i = 1'b0;
    beat("R7 pre", 8'h40, 1'b0);
    @(negedge clk);
    beat("R7 pre", 8'h41, 1'b0);
    req(2'd0, 1'b1, 8'h00);
    @(negedge clk);
    start_i = 1'b0;
    check("R7 abort vld", 32'(beat_vld_o), 32'd0);
    check("R7 abort bad", 32'(bad_len_o), 32'd1);
    @(negedge clk);
    check("R7 abort idle", 32'(beat_vld_o), 32'd0);

    // R8: restart in the middle of a burst
    req(2'd3, 1'b0, 8'h10);
    @(negedge clk);
    start_i = 1'b0;
    beat("R8 old", 8'h10, 1'b0);
    @(negedge clk);
    beat("R8 old", 8'h11, 1'b0);
    req(2'd2, 1'b0, 8'h55);
    @(negedge clk);
    start_i = 1'b0;
    beat("R8 new", 8'h55, 1'b0);
    @(negedge clk);
    beat("R8 new", 8'h56, 1'b0);
    @(negedge clk);
    beat("R8 new", 8'h57, 1'b0);
    @(negedge clk);
    beat("R8 new", 8'h54, 1'b1);
    @(negedge clk);
    check("R8 done", 32'(beat_vld_o), 32'd0);

    // R9: back-to-back on the last beat
    req(2'd1, 1'b0, 8'h30);
    @(negedge clk);
    start_i = 1'b0;
    beat("R9 first", 8'h30, 1'b0);
    @(negedge clk);
    beat("R9 first", 8'h31, 1'b1);
    req(2'd1, 1'b1, 8'h61);
    @(negedge clk);
    start_i = 1'b0;
    beat("R9 chained", 8'h61, 1'b0);
    @(negedge clk);
    beat("R9 chained", 8'h60, 1'b1);
    @(negedge clk);
    check("R9 done", 32'(beat_vld_o), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule